// File: doc/BRIEF.md
# Three-Channel Reload Interval Timer

This peripheral holds three independent 16-bit down-counters, each with a fixed reload value. A host reaches it over a small byte-wide register port with eight offsets. Once the host writes the start command, every channel counts down by one on each cycle in which the `tick` enable is high. When a channel's count runs out, it reloads itself in that same step and latches a pending interrupt flag. The `irq` output is high while any flag is pending.

The host finds out which channel fired by reading the status offset. It acknowledges a channel by reading that channel's low count byte, which clears the channel's flag. Reads are registered: the byte selected on a cycle with `bus_rd` high appears on `bus_rdata` on the following cycle and stays there until the next read.

Start control is a two-state machine. `RUN_IDLE` is the state after reset; there no counter moves. `RUN_ACTIVE` is the counting state. There is one transition, *start*, from `RUN_IDLE` to `RUN_ACTIVE`, taken on a control write with bit 7 set. `RUN_ACTIVE` has only a self-loop, so after start the timer keeps running until reset.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset the machine is in `RUN_IDLE`, the three counts equal their reload values 32, 3200 and 801, no flag is pending, `irq` is 0 and `bus_rdata` is 0.
- R2: In `RUN_IDLE` no count changes, whatever the value of `tick`.
- R3: In `RUN_ACTIVE`, each count greater than 1 drops by exactly one on every cycle with `tick` high, and holds on every cycle with `tick` low.
- R4: In `RUN_ACTIVE` with `tick` high, a count of 1 becomes the channel's reload value on that edge instead of 0, and the channel's pending flag is set.
- R5: `irq` equals the OR of the three pending flags.
- R6: Reading offset 1 returns the pending flags of channels 1, 2 and 3 in bits 0, 1 and 2, with bits 7:3 zero. The data appears the cycle after the read and holds until the next read.
- R7: Offsets 2, 4 and 6 return bits 15:8 of the live counts of channels 1, 2 and 3, and offsets 3, 5 and 7 return bits 7:0. The value is the count as it stood in the read cycle. Offset 0 reads as zero.
- R8: A read of offset 3, 5 or 7 clears the pending flag of channel 1, 2 or 3. A read of any other offset changes no flag and no count.
- R9: A write to offset 0 with bit 7 set takes the *start* transition, so all three channels run from the next cycle on. A write to offset 0 with bit 7 clear, or any write to offsets 1 to 7, leaves the state and the counts unchanged.
- R10: If a clearing read of a channel falls in the same cycle as that channel's reload, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable; one decrement step per high cycle |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt, high while any flag is pending |

## Verification
The properties assume that `bus_rd` and `bus_wr` are never high together. They also assume that every reload value is at least 2, so a count never sits at 1 straight after a reload. The stimulus issues at most one bus access per cycle and uses only the fixed reload values. It times reads of offsets 3 and 7 to land exactly on the reload edge of channels 1 and 3, which exercises the set-wins case. It also mixes cycles with `tick` high and low, so both the hold and the decrement paths are covered.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_t;

    localparam int unsigned CTRL_OFS   = 0;
    localparam int unsigned STATUS_OFS = 1;
    localparam int unsigned START_BIT  = 7;

    function automatic logic [15:0] reload_of(input int unsigned ch);
        case (ch)
            0:       return 16'd32;
            1:       return 16'd3200;
            2:       return 16'd801;
            default: return 16'd100;
        endcase
    endfunction

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              run
);

    run_state_t state_q, state_d;
    logic       start_cmd;

    assign start_cmd = wr && (addr == ADDR_W'(CTRL_OFS)) && wdata[START_BIT];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_IDLE:   if (start_cmd) state_d = RUN_ACTIVE;
            RUN_ACTIVE: state_d = RUN_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run = (state_q == RUN_ACTIVE);
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int unsigned       CNT_W  = 16,
    parameter logic [CNT_W-1:0]  RELOAD = 16'd32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             ack,
    output logic [CNT_W-1:0] count,
    output logic             pend
);

    logic step, wrap;

    assign step = run && tick;
    assign wrap = step && (count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= RELOAD;
            pend  <= 1'b0;
        end else begin
            if (step) count <= wrap ? RELOAD : count - CNT_W'(1);
            if (wrap)     pend <= 1'b1;
            else if (ack) pend <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cnt,
    input  logic [NUM_CH-1:0]            pend,
    output logic [NUM_CH-1:0]            ack,
    output logic [7:0]                   rdata
);

    logic [7:0] sel;

    always_comb begin
        sel = '0;
        ack = '0;
        if (addr == ADDR_W'(STATUS_OFS)) begin
            sel[NUM_CH-1:0] = pend;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(2*c + 2)) sel = cnt[c][CNT_W-1 -: 8];
            if (addr == ADDR_W'(2*c + 3)) begin
                sel    = cnt[c][7:0];
                ack[c] = rd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= sel;
    end

endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned ADDR_W = $clog2(2*NUM_CH + 2)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    output logic       irq
);

    logic                         run;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt;
    logic [NUM_CH-1:0]            pend;
    logic [NUM_CH-1:0]            ack;

    tmr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr[ADDR_W-1:0]),
        .wdata (bus_wdata),
        .run   (run)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_channel #(
            .CNT_W  (CNT_W),
            .RELOAD (CNT_W'(reload_of(g)))
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .tick  (tick),
            .ack   (ack[g]),
            .count (cnt[g]),
            .pend  (pend[g])
        );
    end

    tmr_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .addr  (bus_addr[ADDR_W-1:0]),
        .cnt   (cnt),
        .pend  (pend),
        .ack   (ack),
        .rdata (bus_rdata)
    );

    assign irq = |pend;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned CNT_W  = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick,
    input logic [2:0]                   bus_addr,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [7:0]                   bus_wdata,
    input logic                         irq,
    input logic                         run,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CH-1:0]            pend
);

    // R5: combined interrupt tracks the per-channel flags
    a_r5_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|pend));

    // R9: once started, the run state never drops back
    a_r9_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

    // R9: a control write without the start bit leaves the state idle
    a_r9_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(bus_wr && bus_addr == 3'd0 && bus_wdata[START_BIT])) |=> !run);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R2: idle counters hold
        a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> $stable(cnt[g]));

        // R3: decrement by one
        a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
            (run && tick && cnt[g] > CNT_W'(1)) |=> cnt[g] == $past(cnt[g]) - CNT_W'(1));

        // R3: no tick, no change
        a_r3_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> $stable(cnt[g]));

        // R4: reload on expiry
        a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
            (run && tick && cnt[g] == CNT_W'(1)) |=> cnt[g] == CNT_W'(reload_of(g)));

        // R10: expiry sets the flag even with a clearing read in the same cycle
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (run && tick && cnt[g] == CNT_W'(1)) |=> pend[g]);

        // R8: a clearing read without expiry drops the flag
        a_r8_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && bus_addr == 3'(2*g + 3) && !(run && tick && cnt[g] == CNT_W'(1)))
            |=> !pend[g]);
    end

endmodule

bind tri_interval_timer tmr_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .run       (run),
    .cnt       (cnt),
    .pend      (pend)
);

// File: tb/sim_tri_interval_timer.sv
`timescale 1ns/1ps
module sim_tri_interval_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;

    always #2 clk = ~clk;

    tri_interval_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    int    n_vec  = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    done   = 0;
    string tag    = "R1";

    int    reload_v [3] = '{32, 3200, 801};
    int    m_cnt [3];
    bit    m_pend [3];
    bit    m_run;
    int    m_rdata;
    int    last_addr;

    function automatic int model_read(int a);
        if (a == 1) return m_pend[0] | (m_pend[1] << 1) | (m_pend[2] << 2);
        if (a >= 2) begin
            if (a % 2 == 0) return (m_cnt[(a-2)/2] >> 8) & 8'hFF;
            return m_cnt[(a-2)/2] & 8'hFF;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i]  = reload_v[i];
                m_pend[i] = 0;
            end
            m_run     = 0;
            m_rdata   = 0;
            last_addr = 0;
        end else begin
            bit wrapped [3];
            if (bus_rd) begin
                m_rdata   = model_read(int'(bus_addr));
                last_addr = int'(bus_addr);
            end
            for (int i = 0; i < 3; i++) begin
                wrapped[i] = 0;
                if (m_run && tick) begin
                    if (m_cnt[i] == 1) begin
                        m_cnt[i]   = reload_v[i];
                        wrapped[i] = 1;
                    end else m_cnt[i] = m_cnt[i] - 1;
                end
                if (bus_rd && int'(bus_addr) == 2*i + 3) m_pend[i] = 0;
                if (wrapped[i]) m_pend[i] = 1;
            end
            if (bus_wr && bus_addr == 3'd0 && bus_wdata[7]) m_run = 1;
        end
    end

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic compare();
        string rtag;
        check({tag, " R5 irq"}, int'(irq), int'(m_pend[0] | m_pend[1] | m_pend[2]));
        if (last_addr == 1) rtag = "R6";
        else if (last_addr >= 2 && last_addr % 2 == 1) rtag = "R8";
        else rtag = "R7";
        check({tag, " ", rtag, " rdata"}, int'(bus_rdata), m_rdata);
    endtask

    task automatic step(bit t, bit rd, bit wr, int a, int d);
        tick      = t;
        bus_rd    = rd;
        bus_wr    = wr;
        bus_addr  = 3'(a);
        bus_wdata = 8'(d);
        @(posedge clk);
        #1;
        compare();
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        tag = "R1";
        check("R1 irq", int'(irq), 0);
        check("R1 rdata", int'(bus_rdata), 0);
        for (int a = 0; a < 8; a++) step(0, 1, 0, a, 0);
        // R2: stopped channels ignore tick
        tag = "R2";
        for (int i = 0; i < 40; i++) step(1, (i % 3) == 0, 0, i % 8, 0);
        for (int a = 0; a < 8; a++) step(1, 1, 0, a, 0);
        // R9: non-start writes ignored
        tag = "R9";
        step(1, 0, 1, 0, 8'h7F);
        for (int a = 1; a < 8; a++) step(1, 0, 1, a, 8'hFF);
        for (int a = 0; a < 8; a++) step(1, 1, 0, a, 0);
        // R9: start
        step(1, 0, 1, 0, 8'h80);
        // R3 R4 R8 R10: running with mixed tick and reads
        for (int i = 0; i < 7000; i++) begin
            bit t = (i % 5) != 3;
            tag = "R3";
            if (t && m_cnt[0] == 1) begin
                tag = "R10";
                step(1, 1, 0, 3, 0);
            end else if (t && m_cnt[2] == 1 && (i % 2) == 0) begin
                tag = "R10";
                step(1, 1, 0, 7, 0);
            end else if (m_cnt[0] == 32) begin
                tag = "R4";
                step(t, 1, 0, 1, 0);
            end else if (i % 7 == 0) begin
                step(t, 1, 0, (i / 7) % 8, 0);
            end else if (i % 97 == 0) begin
                tag = "R9";
                step(t, 0, 1, 0, 8'h80);
            end else begin
                step(t, 0, 0, 0, 0);
            end
        end
        // R8: final acknowledgements and status
        tag = "R8";
        step(0, 1, 0, 1, 0);
        step(0, 1, 0, 3, 0);
        step(0, 1, 0, 5, 0);
        step(0, 1, 0, 7, 0);
        step(0, 1, 0, 1, 0);
        step(0, 0, 0, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule